// File: doc/BRIEF.md
# Pilot Identification Tone Detector

This block watches a one-bit identification waveform and decides whether it carries the stereo identification tone (117.48 Hz), the dual-sound identification tone (274.12 Hz), or neither. The waveform comes from an upstream synchronous demodulator. Each rising edge starts a new period. The block measures the length of every period in clock-enable ticks and tests it against one narrow frequency window per tone. A period only counts as a hit when the period before it also fell inside the same window.

Hits and misses drive one saturating up/down integrator per tone. Each integrator has separate set and release levels, so an identification bit turns on slowly and turns off only after a run of misses. If the waveform stops toggling, a timeout counts as a miss, so a vanished tone still decays. The mode logic can issue a clear request, which empties both detectors and holds them empty while it stays asserted. When the stereo and dual decisions would both be true at once, the dual bit wins.

Top module: `pilot_tone_ident`

## Requirements
- R1: While power-on reset (`rstN` low) is applied, and after it is released until detection occurs, both `stereoId` and `dualId` are 0.
- R2: A period is the number of ticks (clock cycles with `tickEn` = 1) between successive rising edges of `idBit`. Cycles with `tickEn` = 0 neither count nor change the outputs, unless `clearReq` is set.
- R3: A stereo period is in window when `ceil(TICK_HZ*1000/(117480+1100)) <= P <= floor(TICK_HZ*1000/(117480-1100))`. At `TICK_HZ` = 40000 this is 338..343 ticks.
- R4: A dual period is in window when `ceil(TICK_HZ*1000/(274120+1150)) <= P <= floor(TICK_HZ*1000/(274120-1150))`. At `TICK_HZ` = 40000 this is exactly 146 ticks.
- R5: A period is a hit for a tone only if it and the previous completed period of the same tone were both in window. After a clear, the first rising edge only starts measurement, so the first completed period is never a hit.
- R6: Each tone level counts up by one on a hit and down by one on a miss, saturating at 0 and at FULL. The tone's raw bit sets when the level is at least ON. So after a clear, a train of n constant in-window periods (n+1 edges) sets the bit exactly when n-1 >= ON.
- R7: The raw bit clears only when the level is at most OFF. From a saturated level, the bit stays on through FULL-OFF-1 consecutive misses and drops on miss number FULL-OFF.
- R8: When no rising edge arrives for TIMEOUT = 2*max(stereo upper bound, dual upper bound) ticks, a miss is recorded for both tones. This repeats every TIMEOUT ticks while the line stays idle.
- R9: `clearReq` zeroes both outputs on the next clock edge and keeps all detection state cleared while it is held. After release, detection restarts from an empty state.
- R10: `stereoId` and `dualId` are never 1 together. When both raw decisions are on, only `dualId` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| tickEn | input | 1 | Clock enable; one tick per high cycle |
| idBit | input | 1 | One-bit identification waveform from the demodulator |
| clearReq | input | 1 | Clear request from the mode logic (all-mute) |
| stereoId | output | 1 | Registered stereo identification bit |
| dualId | output | 1 | Registered dual identification bit |

## Verification
Corrupted period measurement or window bounds show up as a wrong decision for periods one tick inside or outside a window edge. This becomes visible within about a dozen periods of a constant train. A stuck or missing tracking flag, a non-saturating integrator or a wrong hysteresis level shows up as an identification bit that changes one or more periods early or late. The bench therefore counts edges exactly against the set and release levels. A lost timeout shows only as a bit that never drops once the line goes quiet, which takes about thirteen timeout intervals to expose.

// File: rtl/tone_id_pkg.sv
package tone_id_pkg;

  // Strobes from the edge/period control to the tone datapath
  typedef struct packed {
    logic clear;    // flush every detector
    logic period;   // a full period has been measured (value valid)
    logic timeout;  // line idle too long: count a miss
  } idStrobe_t;

  // Shortest period (ticks) still inside a window: ceil(f_tick / f_high)
  function automatic int ticksMin(int tickHz, int toneMhz, int halfMhz);
    longint num;
    longint den;
    num = longint'(tickHz) * 64'sd1000;
    den = longint'(toneMhz + halfMhz);
    return int'((num + den - 64'sd1) / den);
  endfunction

  // Longest period (ticks) still inside a window: floor(f_tick / f_low)
  function automatic int ticksMax(int tickHz, int toneMhz, int halfMhz);
    longint num;
    longint den;
    num = longint'(tickHz) * 64'sd1000;
    den = longint'(toneMhz - halfMhz);
    return int'(num / den);
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tone_id_ctrl.sv
module tone_id_ctrl
  import tone_id_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1718,
  parameter int CNT_W         = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             idBit,
  input  logic             clearReq,
  output idStrobe_t        strobe,
  output logic [CNT_W-1:0] periodVal
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic [2:0]       syncQ;
  logic             riseNow;
  logic             armed;
  logic [CNT_W-1:0] periodCnt;
  logic             atLimit;

  // Two-stage synchroniser plus one history stage, advanced per tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else if (tickEn) begin
      syncQ <= {syncQ[1:0], idBit};
    end
  end

  assign riseNow = syncQ[1] & ~syncQ[2];
  assign atLimit = (periodCnt == LAST_CNT);

  // Period counter: restarts on every rising edge, wraps on timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      periodCnt <= '0;
    end else if (clearReq) begin
      armed     <= 1'b0;
      periodCnt <= '0;
    end else if (tickEn) begin
      if (riseNow) begin
        armed     <= 1'b1;
        periodCnt <= '0;
      end else if (armed) begin
        periodCnt <= atLimit ? '0 : periodCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clear   = clearReq;
    strobe.period  = tickEn & ~clearReq & armed & riseNow;
    strobe.timeout = tickEn & ~clearReq & armed & ~riseNow & atLimit;
    periodVal      = periodCnt + 1'b1;
  end

endmodule

// File: rtl/tone_id_chan.sv
module tone_id_chan
  import tone_id_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int WIN_LO  = 844,
  parameter int WIN_HI  = 859,
  parameter int FULL    = 110,
  parameter int ON_LVL  = 48,
  parameter int OFF_LVL = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  idStrobe_t        strobe,
  input  logic [CNT_W-1:0] periodVal,
  output logic             idRaw
);

  localparam int               LVL_W = $clog2(FULL + 1);
  localparam logic [CNT_W-1:0] LO_V  = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] HI_V  = CNT_W'(WIN_HI);
  localparam logic [LVL_W-1:0] FULL_V = LVL_W'(FULL);
  localparam logic [LVL_W-1:0] ON_V   = LVL_W'(ON_LVL);
  localparam logic [LVL_W-1:0] OFF_V  = LVL_W'(OFF_LVL);

  logic             inWin;
  logic             prevIn;
  logic             hit;
  logic [LVL_W-1:0] level;

  assign inWin = (periodVal >= LO_V) && (periodVal <= HI_V);
  assign hit   = inWin & prevIn;

  // Tracking flag and saturating integrator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= 1'b0;
      level  <= '0;
    end else if (strobe.clear) begin
      prevIn <= 1'b0;
      level  <= '0;
    end else if (strobe.period) begin
      prevIn <= inWin;
      if (hit) begin
        if (level != FULL_V) level <= level + 1'b1;
      end else if (level != '0) begin
        level <= level - 1'b1;
      end
    end else if (strobe.timeout) begin
      prevIn <= 1'b0;
      if (level != '0) level <= level - 1'b1;
    end
  end

  // Hysteresis between set and release levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idRaw <= 1'b0;
    end else if (strobe.clear) begin
      idRaw <= 1'b0;
    end else if (tickEn) begin
      if (level >= ON_V)       idRaw <= 1'b1;
      else if (level <= OFF_V) idRaw <= 1'b0;
    end
  end

endmodule

// File: rtl/tone_id_datapath.sv
module tone_id_datapath
  import tone_id_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int S_LO     = 844,
  parameter int S_HI     = 859,
  parameter int D_LO     = 364,
  parameter int D_HI     = 366,
  parameter int S_FULL   = 110,
  parameter int S_ON     = 48,
  parameter int S_OFF    = 40,
  parameter int D_FULL   = 258,
  parameter int D_ON     = 110,
  parameter int D_OFF    = 94
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  idStrobe_t        strobe,
  input  logic [CNT_W-1:0] periodVal,
  output logic             stereoId,
  output logic             dualId
);

  localparam int NUM_TONES = 2;  // index 0 stereo, 1 dual

  logic [NUM_TONES-1:0] rawId;

  for (genvar g = 0; g < NUM_TONES; g++) begin : gTone
    tone_id_chan #(
      .CNT_W  (CNT_W),
      .WIN_LO ((g == 0) ? S_LO   : D_LO),
      .WIN_HI ((g == 0) ? S_HI   : D_HI),
      .FULL   ((g == 0) ? S_FULL : D_FULL),
      .ON_LVL ((g == 0) ? S_ON   : D_ON),
      .OFF_LVL((g == 0) ? S_OFF  : D_OFF)
    ) uChan (
      .clk      (clk),
      .rstN     (rstN),
      .tickEn   (tickEn),
      .strobe   (strobe),
      .periodVal(periodVal),
      .idRaw    (rawId[g])
    );
  end

  // Output register with dual priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stereoId <= 1'b0;
      dualId   <= 1'b0;
    end else if (strobe.clear) begin
      stereoId <= 1'b0;
      dualId   <= 1'b0;
    end else if (tickEn) begin
      dualId   <= rawId[1];
      stereoId <= rawId[0] & ~rawId[1];
    end
  end

endmodule

// File: rtl/pilot_tone_ident.sv
module pilot_tone_ident
  import tone_id_pkg::*;
#(
  parameter int TICK_HZ         = 100000,
  parameter int STEREO_MHZ      = 117480,
  parameter int STEREO_HALF_MHZ = 1100,
  parameter int DUAL_MHZ        = 274120,
  parameter int DUAL_HALF_MHZ   = 1150,
  parameter int STEREO_FULL     = 110,
  parameter int STEREO_ON       = 48,
  parameter int STEREO_OFF      = 40,
  parameter int DUAL_FULL       = 258,
  parameter int DUAL_ON         = 110,
  parameter int DUAL_OFF        = 94
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic idBit,
  input  logic clearReq,
  output logic stereoId,
  output logic dualId
);

  localparam int S_LO          = ticksMin(TICK_HZ, STEREO_MHZ, STEREO_HALF_MHZ);
  localparam int S_HI          = ticksMax(TICK_HZ, STEREO_MHZ, STEREO_HALF_MHZ);
  localparam int D_LO          = ticksMin(TICK_HZ, DUAL_MHZ, DUAL_HALF_MHZ);
  localparam int D_HI          = ticksMax(TICK_HZ, DUAL_MHZ, DUAL_HALF_MHZ);
  localparam int TIMEOUT_TICKS = 2 * maxOf(S_HI, D_HI);
  localparam int CNT_W         = $clog2(TIMEOUT_TICKS + 1);

  idStrobe_t        strobe;
  logic [CNT_W-1:0] periodVal;

  tone_id_ctrl #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .CNT_W        (CNT_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .idBit    (idBit),
    .clearReq (clearReq),
    .strobe   (strobe),
    .periodVal(periodVal)
  );

  tone_id_datapath #(
    .CNT_W (CNT_W),
    .S_LO  (S_LO),
    .S_HI  (S_HI),
    .D_LO  (D_LO),
    .D_HI  (D_HI),
    .S_FULL(STEREO_FULL),
    .S_ON  (STEREO_ON),
    .S_OFF (STEREO_OFF),
    .D_FULL(DUAL_FULL),
    .D_ON  (DUAL_ON),
    .D_OFF (DUAL_OFF)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strobe   (strobe),
    .periodVal(periodVal),
    .stereoId (stereoId),
    .dualId   (dualId)
  );

endmodule

// File: rtl/pilot_tone_ident_chk.sv
module pilot_tone_ident_chk (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic clearReq,
  input logic stereoId,
  input logic dualId
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!stereoId && !dualId));

  // R10
  exclusive_ids_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stereoId && dualId));

  // R9
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (!stereoId && !dualId));

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !clearReq) |=> ($stable(stereoId) && $stable(dualId)));

  // R9
  dual_rise_not_in_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dualId) |-> !$past(clearReq));

  // R9
  stereo_rise_not_in_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stereoId) |-> !$past(clearReq));

endmodule

bind pilot_tone_ident pilot_tone_ident_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .clearReq(clearReq),
  .stereoId(stereoId),
  .dualId  (dualId)
);

// File: tb/tb_pilot_tone_ident.sv
module tb_pilot_tone_ident;

  localparam int TICK = 40000;
  localparam int FULL = 15;
  localparam int ONL  = 10;
  localparam int OFFL = 2;

  function automatic int winLo(int c, int h);
    return (TICK * 1000 + (c + h) - 1) / (c + h);
  endfunction
  function automatic int winHi(int c, int h);
    return (TICK * 1000) / (c - h);
  endfunction

  localparam int SLO = (TICK * 1000 + 118580 - 1) / 118580;
  localparam int SHI = (TICK * 1000) / 116380;
  localparam int TO  = 2 * SHI;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic idBit = 1'b0;
  logic clearReq = 1'b0;
  logic stereoId;
  logic dualId;
  logic halfRate = 1'b0;
  logic bothSeen = 1'b0;
  int   checks = 0;
  int   failures = 0;
  int   sLo, sHi, dLo, dHi;

  always #4 clk = ~clk;

  pilot_tone_ident #(
    .TICK_HZ    (TICK),
    .STEREO_FULL(FULL), .STEREO_ON(ONL), .STEREO_OFF(OFFL),
    .DUAL_FULL  (FULL), .DUAL_ON  (ONL), .DUAL_OFF  (OFFL)
  ) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .idBit(idBit),
    .clearReq(clearReq), .stereoId(stereoId), .dualId(dualId)
  );

  always @(negedge clk) if (stereoId && dualId) bothSeen = 1'b1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic oneTick();
    tickEn = 1'b1;
    @(negedge clk);
    if (halfRate) begin
      tickEn = 1'b0;
      @(negedge clk);
      tickEn = 1'b1;
    end
  endtask

  task automatic drive(int p, int n);
    for (int i = 0; i < n; i++) begin
      idBit = 1'b1;
      repeat (p / 2) oneTick();
      idBit = 1'b0;
      repeat (p - p / 2) oneTick();
    end
  endtask

  task automatic idle(int k);
    repeat (k) oneTick();
  endtask

  task automatic doClear();
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
  endtask

  initial begin
    sLo = winLo(117480, 1100); sHi = winHi(117480, 1100);
    dLo = winLo(274120, 1150); dHi = winHi(274120, 1150);
    repeat (5) @(negedge clk);
    check("R1 stereo in reset", stereoId, 0);
    check("R1 dual in reset", dualId, 0);
    rstN = 1'b1;
    idle(20);
    check("R1 stereo after reset", stereoId, 0);
    check("R1 dual after reset", dualId, 0);

    // R3 sweep across stereo window edges
    for (int p = sLo - 2; p <= sHi + 2; p++) begin
      doClear();
      drive(p, 12); idle(4);
      check($sformatf("R3 stereo P=%0d", p), stereoId, (p >= sLo && p <= sHi) ? 1 : 0);
      check($sformatf("R4 dual quiet P=%0d", p), dualId, 0);
    end
    // R4 sweep across dual window edges
    for (int p = dLo - 2; p <= dHi + 2; p++) begin
      doClear();
      drive(p, 12); idle(4);
      check($sformatf("R4 dual P=%0d", p), dualId, (p >= dLo && p <= dHi) ? 1 : 0);
      check($sformatf("R3 stereo quiet P=%0d", p), stereoId, 0);
    end

    // R6 set threshold: 11 edges give ON-1 hits, 12 edges give ON hits
    doClear(); drive(340, 11); idle(4);
    check("R6 one hit short", stereoId, 0);
    doClear(); drive(340, 12); idle(4);
    check("R6 exactly ON hits", stereoId, 1);

    // R5 tracking: in,in,out triples never build up
    doClear();
    for (int i = 0; i < 10; i++) begin
      drive(340, 2); drive(300, 1);
    end
    idle(4);
    check("R5 isolated in-window periods", stereoId, 0);

    // R7 hysteresis on dual from saturation
    doClear(); drive(146, 20); drive(200, 13); idle(4);
    check("R7 dual held at FULL-OFF-1 misses", dualId, 1);
    drive(200, 1); idle(4);
    check("R7 dual drops at FULL-OFF misses", dualId, 0);

    // R10 dual priority while both raw decisions are on
    doClear(); drive(340, 20); idle(4);
    check("R6 stereo on before dual", stereoId, 1);
    drive(146, 13); idle(4);
    check("R10 dual wins dual", dualId, 1);
    check("R10 stereo suppressed", stereoId, 0);
    check("R10 never both", bothSeen, 0);

    // R8 repeated timeout misses on an idle line
    doClear(); drive(340, 20);
    idle((TO * 25) / 2 - 340);
    check("R8 still on after 12 timeouts", stereoId, 1);
    idle(TO);
    check("R8 off after 13 timeouts", stereoId, 0);

    // R9 clear held during a valid train
    doClear(); drive(340, 20); idle(4);
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk);
    check("R9 cleared next edge", stereoId, 0);
    drive(340, 20);
    check("R9 held cleared", stereoId, 0);
    clearReq = 1'b0;
    drive(340, 12); idle(4);
    check("R9 restart after release", stereoId, 1);

    // R2 ticks, not clock cycles, are counted
    doClear();
    halfRate = 1'b1;
    drive(340, 12); idle(4);
    halfRate = 1'b0;
    check("R2 half-rate tick train", stereoId, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule